// File: doc/BRIEF.md
# Playback Sample Byte Assembler

This block sits between an 8-bit host data path and the playback side of an audio converter. The host delivers sample data one byte at a time. It does so either through a request/acknowledge DMA handshake or through programmed writes to a data port. The block assembles those bytes into 16-bit left and right samples and pushes each complete pair into a small FIFO. A sample-rate strobe drains that FIFO into the converter-facing sample outputs.

Four formats are supported: 8-bit mono, 8-bit stereo, 16-bit mono and 16-bit stereo. Three status bits tell a polling host exactly which byte is expected next: a byte-position bit, a channel-position bit and a ready bit. When the strobe finds the FIFO empty, a sticky underrun flag is raised and the previous sample is replayed.

Top module: `pb_byte_asm`

## Requirements
- R1: During and after a synchronous active-low reset, both sample outputs read 0, `st_underrun` reads 0, and with playback disabled `dma_req` and `st_ready` read 0.
- R2: `dma_req` and `st_ready` are both 0 whenever the FIFO is full or playback is disabled. `dma_req` is also 0 whenever `cfg_pio_mode` is 1. `st_ready` is 1 whenever playback is enabled and the FIFO is not full, in either transfer mode.
- R3: A byte is taken only on the clock where `host_wr` is first seen high after being low, and only when the transfer is qualified: by `dma_ack` when `cfg_pio_mode`=0, or by `host_pio_sel` when `cfg_pio_mode`=1. A strobe held high for several clocks counts once. A write qualified through the unselected path is ignored and leaves the byte position unchanged.
- R4: Before each byte, `st_upper` reads 0 if a low byte is expected and 1 if a high byte is expected or any 8-bit format is selected. `st_right` reads 1 only when a right-channel byte is expected. Format encoding: `cfg_wide`=1 selects 16-bit and `cfg_stereo`=1 selects stereo.
- R5: An 8-bit byte b is unsigned. It becomes the 16-bit sample {~b[7], b[6:0], 8'h00}.
- R6: In 16-bit formats, each channel receives its low byte before its high byte. In stereo formats, left is delivered before right, so a 16-bit stereo pair takes four bytes and an 8-bit stereo pair takes two.
- R7: In mono formats, the assembled sample appears on both the left and the right outputs.
- R8: The FIFO holds 16 pairs and drains in write order. While it is full, a write is ignored.
- R9: A `smp_tick` with a non-empty FIFO pops one pair. The popped pair appears on `smp_left`/`smp_right` from the clock after the tick.
- R10: A `smp_tick` with an empty FIFO while playback is enabled sets `st_underrun` and leaves the outputs holding the last sample. A one-clock `unr_clr` pulse clears the flag. A new underrun in the same clock as a clear wins. A tick while disabled does not set the flag.
- R11: Disabling playback, or changing the format, returns the byte sequence to the first byte of a pair (`st_upper`/`st_right` as for byte 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_play_en | input | 1 | Playback enable |
| cfg_pio_mode | input | 1 | 1 = programmed writes, 0 = DMA handshake |
| cfg_stereo | input | 1 | 1 = stereo, 0 = mono |
| cfg_wide | input | 1 | 1 = 16-bit samples, 0 = 8-bit samples |
| host_wr | input | 1 | Host write strobe, rising edge takes data |
| host_pio_sel | input | 1 | Programmed-write data port select |
| dma_ack | input | 1 | DMA acknowledge |
| host_data | input | 8 | Write data byte |
| dma_req | output | 1 | DMA request |
| st_upper | output | 1 | Next byte is a high byte (or any 8-bit format) |
| st_right | output | 1 | Next byte belongs to the right channel |
| st_ready | output | 1 | Next host write will be taken |
| unr_clr | input | 1 | Write-one-to-clear pulse for the underrun flag |
| smp_tick | input | 1 | Sample-rate drain strobe |
| st_underrun | output | 1 | Sticky playback underrun |
| smp_left | output | 16 | Left sample to the converter |
| smp_right | output | 16 | Right sample to the converter |

## Verification
The hardest state to reach from the ports is a full FIFO. Reaching it needs sixteen complete pairs with no drain in between, and then a write that must be dropped. The stimulus gets there with single-byte 8-bit mono writes, using a distinct value per pair. It then drains all sixteen in order. The seventeenth strobe finds the FIFO empty, which shows that the dropped byte never entered and that the output holds. The same empty state is then used to land a clear and a new underrun in one clock.

// File: rtl/pb_pkg.sv
// Shared widths, the sample pair type and the 8-to-16-bit widening rule.
// Assumes a byte width of at least 2 bits.
package pb_pkg;
    parameter int PB_BYTE_W = 8;
    localparam int PB_SMP_W = 2 * PB_BYTE_W;

    typedef logic [PB_SMP_W-1:0] pb_smp_t;

    typedef struct packed {
        pb_smp_t left;
        pb_smp_t right;
    } pb_pair_t;

    // Unsigned byte to signed 16-bit: flip the MSB, left-justify.
    function automatic pb_smp_t pb_widen(input logic [PB_BYTE_W-1:0] b);
        return {~b[PB_BYTE_W-1], b[PB_BYTE_W-2:0], {PB_BYTE_W{1'b0}}};
    endfunction
endpackage

// File: rtl/pb_seq.sv
// Byte sequencer: tracks which byte of which channel comes next, collects
// bytes and emits one push with a complete left/right pair.
// Assumes take is only asserted when the FIFO can accept a push.
module pb_seq
    import pb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 stereo,
    input  logic                 wide,
    input  logic                 take,
    input  logic [PB_BYTE_W-1:0] byte_i,
    output logic                 push,
    output pb_pair_t             pair_o,
    output logic                 upper,
    output logic                 right
);
    logic [1:0]           idx;
    logic [1:0]           last;
    logic [1:0]           fmt_q;
    logic                 fmt_chg;
    logic [PB_BYTE_W-1:0] lo_q;
    pb_smp_t              left_q;
    pb_smp_t              val;

    // Position decode and sample value for the byte now on the bus.
    always_comb begin
        last        = {stereo & wide, stereo | wide};
        fmt_chg     = (fmt_q != {stereo, wide});
        upper       = ~wide | idx[0];
        right       = stereo & (wide ? idx[1] : idx[0]);
        val         = wide ? {byte_i, lo_q} : pb_widen(byte_i);
        push        = take & ~fmt_chg & (idx == last);
        pair_o.left = stereo ? left_q : val;
        pair_o.right = val;
    end

    // Advance the byte position and hold partial bytes and the left sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx    <= '0;
            fmt_q  <= '0;
            lo_q   <= '0;
            left_q <= '0;
        end else begin
            fmt_q <= {stereo, wide};
            if (!en || fmt_chg) begin
                idx <= '0;
            end else if (take) begin
                if (!upper)
                    lo_q <= byte_i;
                if (upper && !right)
                    left_q <= val;
                idx <= (idx == last) ? 2'd0 : idx + 2'd1;
            end
        end
    end

    p_idx_le_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        en && !fmt_chg |-> idx <= last);
    p_push_on_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> upper);
endmodule

// File: rtl/pb_fifo.sv
// Pair FIFO: DEPTH entries, first-word read data shown while not empty.
// Assumes DEPTH is a power of two and callers never push when full
// or pop when empty.
module pb_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;
    logic [CW-1:0] cnt;

    // Flags and head-of-queue data.
    always_comb begin
        full  = (cnt == CW'(DEPTH));
        empty = (cnt == '0);
        rdata = mem[rp];
    end

    // Storage write; no reset needed on the data array.
    always_ff @(posedge clk) begin
        if (push)
            mem[wp] <= wdata;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push)
                wp <= wp + AW'(1);
            if (pop)
                rp <= rp + AW'(1);
            if (push && !pop)
                cnt <= cnt + CW'(1);
            else if (pop && !push)
                cnt <= cnt - CW'(1);
        end
    end

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push && !pop |=> cnt == $past(cnt) + CW'(1));
endmodule

// File: rtl/pb_drain.sv
// Drain stage: on each sample strobe, load the next pair or, if none is
// queued, keep the last pair and raise the sticky underrun flag.
// Assumes clr is a single-clock pulse from a host write-one access.
module pb_drain
    import pb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  logic     tick,
    input  logic     clr,
    input  logic     empty,
    input  pb_pair_t head,
    output logic     pop,
    output pb_pair_t cur,
    output logic     unr
);
    // Pop only when a pair is waiting.
    always_comb pop = tick & ~empty;

    // Output register: replaced on pop, otherwise held.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur <= '0;
        else if (pop)
            cur <= head;
    end

    // Sticky underrun: a new event beats a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            unr <= 1'b0;
        else if (tick && empty && en)
            unr <= 1'b1;
        else if (clr)
            unr <= 1'b0;
    end

    p_hold_on_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tick && empty |=> $stable(cur));
    p_unr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        unr && !clr |=> unr);
endmodule

// File: rtl/pb_byte_asm.sv
// Top: qualifies host write strobes, drives the DMA request and status
// bits, and joins the sequencer, the pair FIFO and the drain stage.
// Assumes host strobes are already synchronous to clk.
module pb_byte_asm
    import pb_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_play_en,
    input  logic                 cfg_pio_mode,
    input  logic                 cfg_stereo,
    input  logic                 cfg_wide,
    input  logic                 host_wr,
    input  logic                 host_pio_sel,
    input  logic                 dma_ack,
    input  logic [PB_BYTE_W-1:0] host_data,
    output logic                 dma_req,
    output logic                 st_upper,
    output logic                 st_right,
    output logic                 st_ready,
    input  logic                 unr_clr,
    input  logic                 smp_tick,
    output logic                 st_underrun,
    output logic [PB_SMP_W-1:0]  smp_left,
    output logic [PB_SMP_W-1:0]  smp_right
);
    localparam int PAIR_W = 2 * PB_SMP_W;

    logic     wr_q;
    logic     take;
    logic     push;
    logic     pop;
    logic     full;
    logic     empty;
    pb_pair_t pair_in;
    pb_pair_t head;
    pb_pair_t cur;

    // Remember the strobe level so only its rising edge counts.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_q <= 1'b0;
        else
            wr_q <= host_wr;
    end

    // Transfer qualification, request and ready status.
    always_comb begin
        st_ready  = cfg_play_en & ~full;
        dma_req   = st_ready & ~cfg_pio_mode;
        take      = host_wr & ~wr_q & st_ready &
                    (cfg_pio_mode ? host_pio_sel : dma_ack);
        smp_left  = cur.left;
        smp_right = cur.right;
    end

    pb_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (cfg_play_en),
        .stereo (cfg_stereo),
        .wide   (cfg_wide),
        .take   (take),
        .byte_i (host_data),
        .push   (push),
        .pair_o (pair_in),
        .upper  (st_upper),
        .right  (st_right)
    );

    pb_fifo #(.W(PAIR_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata (pair_in),
        .pop   (pop),
        .rdata (head),
        .full  (full),
        .empty (empty)
    );

    pb_drain u_drain (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cfg_play_en),
        .tick  (smp_tick),
        .clr   (unr_clr),
        .empty (empty),
        .head  (head),
        .pop   (pop),
        .cur   (cur),
        .unr   (st_underrun)
    );
endmodule

// File: tb/tb_pb_byte_asm.sv
`timescale 1ns/1ps
module tb_pb_byte_asm;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_play_en = 1'b0, cfg_pio_mode = 1'b0;
    logic        cfg_stereo = 1'b0, cfg_wide = 1'b0;
    logic        host_wr = 1'b0, host_pio_sel = 1'b0, dma_ack = 1'b0;
    logic [7:0]  host_data = '0;
    logic        unr_clr = 1'b0, smp_tick = 1'b0;
    logic        dma_req, st_upper, st_right, st_ready, st_underrun;
    logic [15:0] smp_left, smp_right;
    int          n_chk = 0;
    int          n_fail = 0;

    always #2 clk = ~clk;

    pb_byte_asm dut (
        .clk(clk), .rst_n(rst_n), .cfg_play_en(cfg_play_en),
        .cfg_pio_mode(cfg_pio_mode), .cfg_stereo(cfg_stereo),
        .cfg_wide(cfg_wide), .host_wr(host_wr), .host_pio_sel(host_pio_sel),
        .dma_ack(dma_ack), .host_data(host_data), .dma_req(dma_req),
        .st_upper(st_upper), .st_right(st_right), .st_ready(st_ready),
        .unr_clr(unr_clr), .smp_tick(smp_tick), .st_underrun(st_underrun),
        .smp_left(smp_left), .smp_right(smp_right)
    );

    // {stereo, wide}, bytes (b0 lowest), expected {left, right}
    localparam logic [65:0] VEC [6] = '{
        {2'b00, 32'h0000_0080, 32'h0000_0000},
        {2'b00, 32'h0000_003C, 32'hBC00_BC00},
        {2'b10, 32'h0000_01FF, 32'h7F00_8100},
        {2'b01, 32'h0000_1234, 32'h1234_1234},
        {2'b11, 32'h9ABC_5678, 32'h5678_9ABC},
        {2'b11, 32'h7FFF_8000, 32'h8000_7FFF}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [7:0] b, input logic via_ack, input logic via_sel);
        @(negedge clk);
        host_data = b; host_wr = 1'b1; dma_ack = via_ack; host_pio_sel = via_sel;
        @(negedge clk);
        host_wr = 1'b0; dma_ack = 1'b0; host_pio_sel = 1'b0;
    endtask

    task automatic tick(input logic clr);
        @(negedge clk);
        smp_tick = 1'b1; unr_clr = clr;
        @(negedge clk);
        smp_tick = 1'b0; unr_clr = 1'b0;
    endtask

    task automatic clr_only();
        @(negedge clk);
        unr_clr = 1'b1;
        @(negedge clk);
        unr_clr = 1'b0;
    endtask

    task automatic set_fmt(input logic st, input logic wd);
        @(negedge clk);
        cfg_stereo = st; cfg_wide = wd;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 left", {16'h0, smp_left}, 32'h0);
        chk("R1 right", {16'h0, smp_right}, 32'h0);
        chk("R1 unr", {31'h0, st_underrun}, 32'h0);
        chk("R1 req", {31'h0, dma_req}, 32'h0);
        chk("R1 ready", {31'h0, st_ready}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        cfg_play_en = 1'b1;
        @(negedge clk);
        chk("R2 req enabled", {31'h0, dma_req}, 32'h1);
        chk("R2 ready enabled", {31'h0, st_ready}, 32'h1);

        // Vector table: R4 status per byte, R5 R6 R7 assembled pair
        foreach (VEC[v]) begin
            set_fmt(VEC[v][65], VEC[v][64]);
            for (int k = 0; k < (VEC[v][64] ? (VEC[v][65] ? 4 : 2) : (VEC[v][65] ? 2 : 1)); k++) begin
                chk("R4 upper", {31'h0, st_upper},
                    {31'h0, ~VEC[v][64] | k[0]});
                chk("R4 right", {31'h0, st_right},
                    {31'h0, VEC[v][65] & (VEC[v][64] ? k[1] : k[0])});
                wr_byte(VEC[v][32 + 8*k +: 8], 1'b1, 1'b0);
            end
            tick(1'b0);
            chk("R5 R6 R7 pair", {smp_left, smp_right}, VEC[v][31:0]);
        end

        // R3: held strobe counts once (16-bit mono)
        set_fmt(1'b0, 1'b1);
        @(negedge clk);
        host_data = 8'h34; host_wr = 1'b1; dma_ack = 1'b1;
        repeat (4) @(negedge clk);
        host_wr = 1'b0; dma_ack = 1'b0;
        chk("R3 held once", {31'h0, st_upper}, 32'h1);
        wr_byte(8'h12, 1'b1, 1'b0);
        tick(1'b0);
        chk("R3 held pair", {smp_left, smp_right}, 32'h1234_1234);

        // R3: programmed-write path
        @(negedge clk);
        cfg_pio_mode = 1'b1;
        @(negedge clk);
        chk("R2 req in pio", {31'h0, dma_req}, 32'h0);
        chk("R2 ready in pio", {31'h0, st_ready}, 32'h1);
        wr_byte(8'h77, 1'b1, 1'b0);
        chk("R3 ack ignored in pio", {31'h0, st_upper}, 32'h0);
        wr_byte(8'hCD, 1'b0, 1'b1);
        wr_byte(8'hAB, 1'b0, 1'b1);
        tick(1'b0);
        chk("R3 pio pair", {smp_left, smp_right}, 32'hABCD_ABCD);
        @(negedge clk);
        cfg_pio_mode = 1'b0;
        wr_byte(8'h55, 1'b0, 1'b1);
        chk("R3 sel ignored in dma", {31'h0, st_upper}, 32'h0);

        // R11: disable mid-pair restarts the sequence
        set_fmt(1'b1, 1'b1);
        wr_byte(8'h11, 1'b1, 1'b0);
        chk("R11 advanced", {31'h0, st_upper}, 32'h1);
        @(negedge clk);
        cfg_play_en = 1'b0;
        @(negedge clk);
        cfg_play_en = 1'b1;
        @(negedge clk);
        chk("R11 upper restart", {31'h0, st_upper}, 32'h0);
        chk("R11 right restart", {31'h0, st_right}, 32'h0);
        wr_byte(8'h22, 1'b1, 1'b0);
        set_fmt(1'b0, 1'b1);
        chk("R11 fmt change restart", {31'h0, st_upper}, 32'h0);

        // R8 R9 R10: fill, drop, drain, underrun
        set_fmt(1'b0, 1'b0);
        for (int i = 0; i < 16; i++)
            wr_byte(8'h80 + 8'(i), 1'b1, 1'b0);
        chk("R8 full req", {31'h0, dma_req}, 32'h0);
        chk("R8 full ready", {31'h0, st_ready}, 32'h0);
        wr_byte(8'hC5, 1'b1, 1'b0);
        for (int i = 0; i < 16; i++) begin
            tick(1'b0);
            chk("R9 drain order", {smp_left, smp_right},
                {8'(i), 8'h00, 8'(i), 8'h00});
        end
        chk("R10 no unr yet", {31'h0, st_underrun}, 32'h0);
        tick(1'b0);
        chk("R10 unr set", {31'h0, st_underrun}, 32'h1);
        chk("R8 R10 hold last", {smp_left, smp_right}, 32'h0F00_0F00);
        clr_only();
        chk("R10 cleared", {31'h0, st_underrun}, 32'h0);
        tick(1'b1);
        chk("R10 set beats clear", {31'h0, st_underrun}, 32'h1);
        clr_only();
        @(negedge clk);
        cfg_play_en = 1'b0;
        tick(1'b0);
        chk("R10 disabled tick", {31'h0, st_underrun}, 32'h0);
        chk("R2 disabled req", {31'h0, dma_req}, 32'h0);

        summary();
        $finish;
    end
endmodule